// File: doc/BRIEF.md
# Cache Prefetch Hint Dispatcher

The load/store pipeline issues cache-touch hints, either for a coming load or for a coming store. This block decides what happens to each hint. It can start a line fill in one of a small pool of line-fill buffers. It can hold the hint until a buffer frees. It can discard the hint. Without hardware coherency there is no ownership difference between the two hint kinds, so a store touch and a load touch take exactly the same path.

In the default mode a hint is only a suggestion. It never holds up the pipeline. When no buffer is free and a later memory access is queued behind the hint, the hint is dropped. When the guaranteed-touch control bit is set, the hint must reach the cache. The block then raises a stall toward the pipeline until a buffer frees, and issues the fill at that point. Buffers are claimed on fill start and released by per-buffer strobes from the fill logic.

Top module: `hint_dispatch`

## Requirements
- R1: After reset no buffer is busy and no hint is held. With no request, `fill_start`, `stall` and `dropped` are all low.
- R2: When some buffer is free, a hint raises `fill_start` combinationally in its own cycle. `fill_buf` gives the lowest-index free buffer and `fill_addr` gives the hint's line address.
- R3: A request on `touch_st` behaves exactly like one on `touch_ld`.
- R4: In default mode, a hint that finds every buffer busy while `access_waiting` is high raises `dropped` for that one cycle. It produces no fill and no stall.
- R5: In default mode, a hint that finds every buffer busy with `access_waiting` low is held without stalling. A released buffer becomes free on the clock edge that samples its release strobe. In the first cycle after that edge, the held hint fills the lowest-index free buffer with its own address.
- R6: A held default-mode hint is dropped, and the hold is cleared, in the first cycle that `access_waiting` is high while every buffer is still busy.
- R7: The guaranteed bit is sampled when the hint arrives. A guaranteed hint that finds every buffer busy raises `stall` in its arrival cycle and in every cycle until a buffer is free. It then fills the lowest-index free buffer with `stall` low. A guaranteed hint that finds a free buffer fills at once with no stall.
- R8: A dropped hint never changes buffer occupancy.
- R9: A buffer becomes busy on allocation and free on its release strobe. An allocation and a release of different buffers in the same cycle both take effect.
- R10: While a hint is held, any newly arriving hint is dropped and the held hint is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_ld | input | 1 | Touch-for-load hint request |
| touch_st | input | 1 | Touch-for-store hint request |
| hint_addr | input | ADDR_W | Line address of the hint |
| guaranteed | input | 1 | Guaranteed-touch mode bit |
| access_waiting | input | 1 | A later memory access is queued behind the hint |
| release_strb | input | NUM_BUF | Per-buffer release strobes |
| fill_start | output | 1 | Start a line fill this cycle |
| fill_buf | output | IDX_W | Buffer index for the fill |
| fill_addr | output | ADDR_W | Line address for the fill |
| stall | output | 1 | Stall request to the pipeline |
| dropped | output | 1 | One-cycle pulse for a discarded hint |

## Verification
The bench builds the block with three buffers and a 16-bit address. With only three buffers it takes just a few hints to fill the pool, so every full-pool path is reached within a few cycles: drop, hold, guaranteed stall and a new hint arriving during a hold. Because the pool is small, the choice of buffer on later fills shows occupancy at the ports. That choice reveals whether a drop left occupancy alone and whether an allocation and a release in the same cycle both took effect.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_FILL,
        ACT_HOLD,
        ACT_DROP
    } act_e;

endpackage

// File: rtl/pfd_pick.sv
module pfd_pick #(
    parameter int NUM_BUF = 3,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_BUF-1:0] busy,
    output logic               any_free,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_BUF-1:0] onehot
);
    // Scan from the top down so the lowest free index is the last one written.
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        onehot   = '0;
        for (int i = NUM_BUF - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                idx      = IDX_W'(i);
                onehot   = NUM_BUF'(1) << i;
            end
        end
    end
endmodule

// File: rtl/pfd_occupancy.sv
module pfd_occupancy #(
    parameter int NUM_BUF = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_en,
    input  logic [NUM_BUF-1:0] alloc_onehot,
    input  logic [NUM_BUF-1:0] release_strb,
    output logic [NUM_BUF-1:0] busy_q
);
    logic [NUM_BUF-1:0] busy_d;

    // Clearing comes before setting, so an allocation and a release of
    // different buffers in one cycle both take effect.
    always_comb begin
        busy_d = busy_q & ~release_strb;
        if (alloc_en) begin
            busy_d = busy_d | alloc_onehot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= busy_d;
        end
    end
endmodule

// File: rtl/pfd_hold.sv
module pfd_hold #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic              load_guar,
    input  logic [ADDR_W-1:0] load_addr,
    output logic              valid_q,
    output logic              guar_q,
    output logic [ADDR_W-1:0] addr_q
);
    typedef struct packed {
        logic              valid;
        logic              guar;
        logic [ADDR_W-1:0] addr;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.valid = 1'b0;
        end
        if (load) begin
            st_d.valid = 1'b1;
            st_d.guar  = load_guar;
            st_d.addr  = load_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_q = st_q.valid;
    assign guar_q  = st_q.guar;
    assign addr_q  = st_q.addr;
endmodule

// File: rtl/hint_dispatch.sv
module hint_dispatch #(
    parameter int NUM_BUF = 3,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               touch_ld,
    input  logic               touch_st,
    input  logic [ADDR_W-1:0]  hint_addr,
    input  logic               guaranteed,
    input  logic               access_waiting,
    input  logic [NUM_BUF-1:0] release_strb,
    output logic               fill_start,
    output logic [IDX_W-1:0]   fill_buf,
    output logic [ADDR_W-1:0]  fill_addr,
    output logic               stall,
    output logic               dropped
);
    import pfd_pkg::*;

    logic [NUM_BUF-1:0] busy_q;
    logic               any_free;
    logic [IDX_W-1:0]   pick_idx;
    logic [NUM_BUF-1:0] pick_onehot;
    logic               hold_valid_q;
    logic               hold_guar_q;
    logic [ADDR_W-1:0]  hold_addr_q;
    logic               hint_req;

    typedef struct packed {
        act_e              held_act;
        act_e              new_act;
        logic              stall;
        logic              hold_load;
        logic              hold_clear;
        logic [ADDR_W-1:0] addr;
    } dec_t;

    dec_t dec_d;

    // Both touch kinds take the same path.
    assign hint_req = touch_ld | touch_st;

    pfd_pick #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_pick (
        .busy     (busy_q),
        .any_free (any_free),
        .idx      (pick_idx),
        .onehot   (pick_onehot)
    );

    always_comb begin
        dec_d            = '0;
        dec_d.held_act   = ACT_IDLE;
        dec_d.new_act    = ACT_IDLE;
        dec_d.addr       = hint_addr;
        if (hold_valid_q) begin
            if (any_free) begin
                dec_d.held_act   = ACT_FILL;
                dec_d.hold_clear = 1'b1;
                dec_d.addr       = hold_addr_q;
            end else if (hold_guar_q) begin
                dec_d.held_act = ACT_HOLD;
                dec_d.stall    = 1'b1;
            end else if (access_waiting) begin
                dec_d.held_act   = ACT_DROP;
                dec_d.hold_clear = 1'b1;
            end else begin
                dec_d.held_act = ACT_HOLD;
            end
            // Only one hint can be held; a newcomer is discarded.
            if (hint_req) begin
                dec_d.new_act = ACT_DROP;
            end
        end else if (hint_req) begin
            if (any_free) begin
                dec_d.new_act = ACT_FILL;
            end else if (guaranteed) begin
                dec_d.new_act   = ACT_HOLD;
                dec_d.hold_load = 1'b1;
                dec_d.stall     = 1'b1;
            end else if (access_waiting) begin
                dec_d.new_act = ACT_DROP;
            end else begin
                dec_d.new_act   = ACT_HOLD;
                dec_d.hold_load = 1'b1;
            end
        end
    end

    assign fill_start = (dec_d.held_act == ACT_FILL) || (dec_d.new_act == ACT_FILL);
    assign fill_buf   = pick_idx;
    assign fill_addr  = dec_d.addr;
    assign stall      = dec_d.stall;
    assign dropped    = (dec_d.held_act == ACT_DROP) || (dec_d.new_act == ACT_DROP);

    pfd_occupancy #(.NUM_BUF(NUM_BUF)) u_occ (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_en     (fill_start),
        .alloc_onehot (pick_onehot),
        .release_strb (release_strb),
        .busy_q       (busy_q)
    );

    pfd_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (dec_d.hold_load),
        .clear     (dec_d.hold_clear),
        .load_guar (guaranteed),
        .load_addr (hint_addr),
        .valid_q   (hold_valid_q),
        .guar_q    (hold_guar_q),
        .addr_q    (hold_addr_q)
    );
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
    parameter int NUM_BUF = 3,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fill_start,
    input logic [IDX_W-1:0]   fill_buf,
    input logic               stall,
    input logic               dropped,
    input logic [NUM_BUF-1:0] busy,
    input logic [NUM_BUF-1:0] release_strb
);
    // R2: a fill only targets a buffer that is free.
    a_r2_fill_into_free: assert property (@(posedge clk) disable iff (!rst_n)
        fill_start |-> !busy[fill_buf]);

    // R9: the allocated buffer is busy in the next cycle.
    a_r9_alloc_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fill_start |=> busy[$past(fill_buf)]);

    // R9: released buffers are free in the next cycle.
    a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (release_strb != '0) |=> ((busy & $past(release_strb)) == '0));

    // R8: a drop leaves occupancy untouched.
    a_r8_drop_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (dropped && !fill_start && release_strb == '0) |=> $stable(busy));

    // R7: stall only while the whole pool is busy, never together with a fill.
    a_r7_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (&busy) && !fill_start);

    // R4: a discarded hint never starts a stall.
    a_r4_drop_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (dropped && !stall) |=> !$rose(stall) || (&busy));
endmodule

bind hint_dispatch pfd_checker #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_start   (fill_start),
    .fill_buf     (fill_buf),
    .stall        (stall),
    .dropped      (dropped),
    .busy         (busy_q),
    .release_strb (release_strb)
);

// File: tb/sim_hint_dispatch.sv
module sim_hint_dispatch;
    localparam int NB = 3;
    localparam int AW = 16;
    localparam int IW = 2;
    localparam int ROWS = 22;
    // {ld, st, guar, wait, rel[3], addr[16], exp_fill, exp_buf[2], exp_stall, exp_drop, exp_addr[16]}
    localparam int VW = 1+1+1+1+3+16+1+2+1+1+16;

    localparam logic [VW-1:0] TBL [ROWS] = '{
        {4'b1000, 3'b000, 16'h0100, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0100}, // R2 first fill b0
        {4'b0100, 3'b000, 16'h0140, 1'b1, 2'd1, 1'b0, 1'b0, 16'h0140}, // R3 store touch b1
        {4'b0000, 3'b000, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000}, // idle
        {4'b1000, 3'b000, 16'h0180, 1'b1, 2'd2, 1'b0, 1'b0, 16'h0180}, // R2 b2, pool full
        {4'b1001, 3'b000, 16'h01C0, 1'b0, 2'd0, 1'b0, 1'b1, 16'h0000}, // R4 drop
        {4'b0000, 3'b010, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000}, // R9 release b1
        {4'b1000, 3'b000, 16'h0200, 1'b1, 2'd1, 1'b0, 1'b0, 16'h0200}, // R8 b1 reused
        {4'b1010, 3'b000, 16'h0240, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0000}, // R7 stall
        {4'b0000, 3'b001, 16'h0000, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0000}, // R7 still stall
        {4'b0000, 3'b000, 16'h0000, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0240}, // R7 fill b0
        {4'b1000, 3'b000, 16'h0280, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000}, // R5 held
        {4'b0000, 3'b000, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000}, // R5 still held
        {4'b1000, 3'b000, 16'h02C0, 1'b0, 2'd0, 1'b0, 1'b1, 16'h0000}, // R10 newcomer drop
        {4'b0000, 3'b100, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000}, // release b2
        {4'b0000, 3'b000, 16'h0000, 1'b1, 2'd2, 1'b0, 1'b0, 16'h0280}, // R5 held fill b2
        {4'b1000, 3'b000, 16'h0300, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000}, // R6 held
        {4'b0001, 3'b000, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b1, 16'h0000}, // R6 drop
        {4'b0000, 3'b111, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000}, // R6 hold gone
        {4'b1010, 3'b000, 16'h0340, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0340}, // R7 guar free
        {4'b1000, 3'b001, 16'h0380, 1'b1, 2'd1, 1'b0, 1'b0, 16'h0380}, // R9 alloc+rel
        {4'b1000, 3'b000, 16'h03C0, 1'b1, 2'd0, 1'b0, 1'b0, 16'h03C0}, // R9 b0 free again
        {4'b1000, 3'b000, 16'h0400, 1'b1, 2'd2, 1'b0, 1'b0, 16'h0400}  // R9 b2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          touch_ld = 1'b0, touch_st = 1'b0;
    logic [AW-1:0] hint_addr = '0;
    logic          guaranteed = 1'b0, access_waiting = 1'b0;
    logic [NB-1:0] release_strb = '0;
    logic          fill_start, stall, dropped;
    logic [IW-1:0] fill_buf;
    logic [AW-1:0] fill_addr;
    int            n_run = 0, n_fail = 0;
    bit            done = 1'b0;

    always #5 clk = ~clk;

    hint_dispatch #(.NUM_BUF(NB), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .touch_ld(touch_ld), .touch_st(touch_st),
        .hint_addr(hint_addr), .guaranteed(guaranteed),
        .access_waiting(access_waiting), .release_strb(release_strb),
        .fill_start(fill_start), .fill_buf(fill_buf), .fill_addr(fill_addr),
        .stall(stall), .dropped(dropped)
    );

    task automatic check(input string req, input logic ef, input logic [IW-1:0] eb,
                         input logic es, input logic ed, input logic [AW-1:0] ea);
        n_run++;
        if (fill_start !== ef || stall !== es || dropped !== ed ||
            (ef && (fill_buf !== eb || fill_addr !== ea))) begin
            n_fail++;
            $display("FAIL %s: got fill=%b buf=%0d addr=%h stall=%b drop=%b, exp fill=%b buf=%0d addr=%h stall=%b drop=%b",
                     req, fill_start, fill_buf, fill_addr, stall, dropped, ef, eb, ea, es, ed);
        end
    endtask

    task automatic drive(input logic [VW-1:0] v);
        {touch_ld, touch_st, guaranteed, access_waiting, release_strb, hint_addr} = v[VW-1:VW-23];
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", 1'b0, '0, 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after reset", 1'b0, '0, 1'b0, 1'b0, '0);
        for (int r = 0; r < ROWS; r++) begin
            drive(TBL[r]);
            #4;
            check($sformatf("table row %0d (R2-R10 mix)", r), TBL[r][20], TBL[r][19:18],
                  TBL[r][17], TBL[r][16], TBL[r][15:0]);
            @(posedge clk); #1;
        end
        // R1: reset with the pool full empties it and clears any hold.
        drive('0);
        touch_ld = 1'b1; hint_addr = 16'h0500;
        #4;
        check("R1 pre-reset hold", 1'b0, '0, 1'b0, 1'b0, '0);
        @(posedge clk); #1;
        touch_ld = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        #4;
        check("R1 hold cleared", 1'b0, '0, 1'b0, 1'b0, '0);
        @(posedge clk); #1;
        touch_st = 1'b1; hint_addr = 16'h0540;
        #4;
        check("R1 pool empty", 1'b1, 2'd0, 1'b0, 1'b0, 16'h0540);
        @(posedge clk); #1;
        touch_st = 1'b0;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout, exp completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule